// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Host

This block is the serial host for a 24-bit sigma-delta converter that exposes eight registers over a four-wire serial link. A client hands it one register access at a time: the register address, the direction, a payload length of zero to four bytes, a continuous-read flag, a wait-for-ready flag and, for writes, the payload. The block builds the 8-bit command byte and clocks it out with the payload, MSB first. It then returns the received payload, right-aligned, together with a one-cycle completion pulse.

The converter signals a finished conversion by pulling its serial output line low, because that pin doubles as the ready flag. For an access marked wait-for-ready, the host lowers chip select and keeps the link to itself without clocking. It starts the command only once the line has gone low.

After reset, the block brings up the converter without any client action. It clocks 48 ones with chip select low, waits a settle interval, reads the one-byte identity register and keeps its low nibble. Only then does it accept client requests.

Top module: `sd_adc_spi_host`

## Requirements
- R1: The command byte is {bit7 = 0, bit6 = 1 for read / 0 for write, bits 5:3 = register address, bit2 = continuous-read flag, bits 1:0 = 0}, and it is the first byte shifted out in every client access.
- R2: The payload length is `req_bytes` bytes (values above 4 act as 4). A write sends bits [8n-1:0] of `req_wdata` MSB first and ignores the upper bits. A read returns the received bytes in `rd_data[8n-1:0]` with the upper bits zero.
- R3: The serial clock idles high whenever chip select is high. The host changes `mosi` only on a falling clock edge and samples `miso` on the rising edge.
- R4: After reset, the host lowers chip select and shifts out 48 consecutive one bits before any other traffic. `busy` is high from reset until initialisation ends.
- R5: After the 48-one sequence, chip select stays high for at least `SETTLE_CYC` system cycles before the next access.
- R6: Initialisation reads register 4 with a one-byte payload (command 0x60). `dev_id` then holds the low 4 bits of the received byte, and `busy` falls.
- R7: With `req_wait_rdy` set, chip select goes low and no serial clock edge occurs until `miso` is seen low. The access then proceeds normally.
- R8: A request presented while `busy` is high is ignored. No extra transaction appears on the link and no extra `done` pulse occurs.
- R9: Each accepted request produces exactly one `done` pulse, one cycle wide. It is issued in the cycle chip select is released, with `rd_data` already valid.
- R10: Chip select stays low from the command byte through the last payload bit. Between transactions it stays high for at least `GAP_HALVES*DIV_HALF` system cycles (two serial clock periods with the default setting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when not busy |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 3 | Register address |
| req_cread | input | 1 | Continuous-read flag placed in the command byte |
| req_wait_rdy | input | 1 | Hold the link until the converter reports ready |
| req_bytes | input | 3 | Payload length in bytes, 0 to 4 |
| req_wdata | input | 32 | Write payload, right-aligned |
| rd_data | output | 32 | Read payload, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Host is initialising or running an access |
| dev_id | output | 4 | Low nibble of the identity register |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data / ready from the converter |

## Verification
A wrong bit count or a wrong state transition shows up within one transaction. It appears as a command byte the converter stub decodes differently, a payload shifted by one or more bits in `rd_data`, or a register read back that does not match what was written. A broken ready wait shows as serial clock edges while the stub still reports busy, visible within a few cycles of the lead-in. Faults in the power-up sequence show before the first client request: a missing 48-one run, a short settle gap or a wrong `dev_id`. Timing faults on the link are caught within the cycle they occur: `mosi` moving while the clock is high, or chip select released early.

// File: rtl/sd_adc_spi_host.sv
module sd_adc_spi_host #(
  parameter int DIV_HALF   = 4,
  parameter int SETTLE_CYC = 125000,
  parameter int GAP_HALVES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic [2:0]  req_addr,
  input  logic        req_cread,
  input  logic        req_wait_rdy,
  input  logic [2:0]  req_bytes,
  input  logic [31:0] req_wdata,
  output logic [31:0] rd_data,
  output logic        done,
  output logic        busy,
  output logic [3:0]  dev_id,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  localparam int GAP_CYC  = GAP_HALVES * DIV_HALF;
  localparam int CMAX     = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int CW       = $clog2(CMAX + 1);
  localparam int RST_BITS = 48;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LO, S_HI, S_WAIT} st_t;
  typedef enum logic [1:0] {P_BOOT, P_RST, P_ID, P_USER} ph_t;

  st_t         st;
  ph_t         ph;
  logic [CW-1:0] cnt;
  logic [47:0] sh;
  logic [31:0] rx;
  logic [5:0]  bits;
  logic [2:0]  nb;
  logic        rd_q, wait_q;
  logic [1:0]  rdy_s;

  function automatic logic [31:0] align_left(input logic [31:0] d, input logic [2:0] n);
    case (n)
      3'd1:    return {d[7:0], 24'h0};
      3'd2:    return {d[15:0], 16'h0};
      3'd3:    return {d[23:0], 8'h0};
      3'd4:    return d;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] low_mask(input logic [2:0] n);
    case (n)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd3:    return 32'h00FF_FFFF;
      3'd4:    return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  wire [2:0] nb_in  = (req_bytes > 3'd4) ? 3'd4 : req_bytes;
  wire [7:0] cmd_in = {1'b0, req_read, req_addr, req_cread, 2'b00};
  wire [31:0] pay_in = req_read ? 32'h0 : align_left(req_wdata, nb_in);
  wire       ready  = ~rdy_s[1];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_WAIT;
      ph      <= P_BOOT;
      cnt     <= CW'(GAP_CYC - 1);
      sh      <= '0;
      rx      <= '0;
      bits    <= '0;
      nb      <= '0;
      rd_q    <= 1'b0;
      wait_q  <= 1'b0;
      rdy_s   <= 2'b11;
      rd_data <= '0;
      done    <= 1'b0;
      dev_id  <= '0;
      sclk    <= 1'b1;
      cs_n    <= 1'b1;
      mosi    <= 1'b1;
    end else begin
      rdy_s <= {rdy_s[0], miso};
      done  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_LEAD;
          ph     <= P_USER;
          cs_n   <= 1'b0;
          cnt    <= CW'(DIV_HALF - 1);
          sh     <= {cmd_in, pay_in, 8'h00};
          bits   <= {nb_in, 3'b000} + 6'd8;
          nb     <= nb_in;
          rd_q   <= req_read;
          wait_q <= req_wait_rdy;
        end
        S_LEAD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!wait_q || ready) begin
            sclk <= 1'b0;
            mosi <= sh[47];
            sh   <= {sh[46:0], 1'b0};
            cnt  <= CW'(DIV_HALF - 1);
            st   <= S_LO;
          end
        end
        S_LO: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            sclk <= 1'b1;
            rx   <= {rx[30:0], miso};
            bits <= bits - 1'b1;
            cnt  <= CW'(DIV_HALF - 1);
            st   <= S_HI;
          end
        end
        S_HI: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (bits != '0) begin
            sclk <= 1'b0;
            mosi <= sh[47];
            sh   <= {sh[46:0], 1'b0};
            cnt  <= CW'(DIV_HALF - 1);
            st   <= S_LO;
          end else begin
            cs_n <= 1'b1;
            mosi <= 1'b1;
            st   <= S_WAIT;
            cnt  <= (ph == P_RST) ? CW'(SETTLE_CYC - 1) : CW'(GAP_CYC - 1);
            if (ph == P_ID) dev_id <= rx[3:0];
            if (ph == P_USER) begin
              done <= 1'b1;
              if (rd_q) rd_data <= rx & low_mask(nb);
            end
          end
        end
        S_WAIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            case (ph)
              P_BOOT: begin
                ph     <= P_RST;
                st     <= S_LEAD;
                cs_n   <= 1'b0;
                cnt    <= CW'(DIV_HALF - 1);
                sh     <= '1;
                bits   <= 6'(RST_BITS);
                wait_q <= 1'b0;
                rd_q   <= 1'b0;
              end
              P_RST: begin
                ph     <= P_ID;
                st     <= S_LEAD;
                cs_n   <= 1'b0;
                cnt    <= CW'(DIV_HALF - 1);
                sh     <= {8'h60, 40'h0};
                bits   <= 6'd16;
                wait_q <= 1'b0;
                rd_q   <= 1'b1;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_adc_spi_host_chk.sv
module sd_adc_spi_host_chk #(
  parameter int GAP_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic done,
  input logic busy
);
  int gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_cnt <= 0;
    else if (cs_n) gap_cnt <= (gap_cnt < 1000000) ? gap_cnt + 1 : gap_cnt;
    else gap_cnt <= 0;
  end

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk); // R3
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && sclk && $past(sclk)) |-> $stable(mosi)); // R3
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> gap_cnt >= GAP_CYC); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $rose(cs_n)); // R9
  AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy); // R8
endmodule

bind sd_adc_spi_host sd_adc_spi_host_chk #(.GAP_CYC(GAP_HALVES * DIV_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .done(done), .busy(busy)
);

// File: tb/sd_adc_spi_host_tb.sv
`timescale 1ns/1ps
module sd_adc_spi_host_tb;
  localparam int DIV_HALF   = 2;
  localparam int SETTLE_CYC = 300;
  localparam int GAP_HALVES = 4;
  localparam int GAP_CYC    = GAP_HALVES * DIV_HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0, req_cread = 1'b0, req_wait_rdy = 1'b0;
  logic [2:0] req_addr = '0, req_bytes = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic done, busy, sclk, cs_n, mosi, miso;
  logic [3:0] dev_id;

  always #2 clk = ~clk;

  sd_adc_spi_host #(.DIV_HALF(DIV_HALF), .SETTLE_CYC(SETTLE_CYC), .GAP_HALVES(GAP_HALVES)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read), .req_addr(req_addr),
    .req_cread(req_cread), .req_wait_rdy(req_wait_rdy), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rd_data(rd_data), .done(done), .busy(busy), .dev_id(dev_id),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // converter stub: samples on rising sclk, drives on falling sclk
  logic [31:0] sregs [8];
  logic [7:0]  scmd = '0, last_cmd = '0;
  logic [31:0] win = '0, sout = '0;
  int sbit = 0, slen = 1, ncmd = 0, ones = 0, dlen = 3;
  bit rst_seen = 0;
  logic rd_phase = 1'b0, sdat = 1'b0, drdy_n = 1'b0;

  function automatic int rlen(input logic [2:0] a);
    case (a)
      3'd0, 3'd4, 3'd5: return 1;
      3'd3:             return dlen;
      default:          return 3;
    endcase
  endfunction

  always @(negedge cs_n) begin
    sbit = 0; rd_phase = 1'b0; ones = 0;
  end

  always @(posedge sclk) if (!cs_n) begin
    ones = mosi ? ones + 1 : 0;
    if (ones >= 48) rst_seen = 1;
    if (sbit < 8) scmd = {scmd[6:0], mosi};
    else win = {win[30:0], mosi};
    sbit++;
    if (sbit == 8 && !scmd[7]) begin
      ncmd++;
      last_cmd = scmd;
      slen = rlen(scmd[5:3]);
      sout = sregs[scmd[5:3]] << (32 - 8 * slen);
    end
    if (sbit > 8 && sbit == 8 + 8 * slen && !scmd[7] && !scmd[6] && scmd[5:3] != 3'd0)
      sregs[scmd[5:3]] = (slen == 4) ? win : (win & ((32'd1 << (8 * slen)) - 32'd1));
  end

  always @(negedge sclk) if (!cs_n) begin
    if (sbit >= 8 && !scmd[7] && scmd[6] && sbit < 8 + 8 * slen) begin
      rd_phase = 1'b1; sdat = sout[31]; sout = sout << 1;
    end else rd_phase = 1'b0;
  end

  assign miso = cs_n ? 1'b1 : (rd_phase ? sdat : drdy_n);

  // link monitor
  int cyc = 0, t_rise = 0, nfall = 0, settle_gap = 0, min_gap = 1000000, viol = 0, ndone = 0;
  logic p_cs = 1'b1, p_sclk = 1'b1, p_mosi = 1'b1;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (!rst_n) nfall = 0;
    else begin
      if (!p_cs && cs_n) t_rise = cyc;
      if (p_cs && !cs_n) begin
        nfall++;
        if (nfall == 2) settle_gap = cyc - t_rise;
        else if (nfall > 2 && (cyc - t_rise) < min_gap) min_gap = cyc - t_rise;
      end
      if (!cs_n && !p_cs && sclk && p_sclk && mosi != p_mosi) viol++;
      if (cs_n && !sclk) viol++;
      if (done) ndone++;
    end
    p_cs = cs_n; p_sclk = sclk; p_mosi = mosi;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic issue(input logic rd, input logic [2:0] a, input logic cr, input logic wr,
                       input logic [2:0] n, input logic [31:0] wd);
    @(negedge clk);
    req_read = rd; req_addr = a; req_cread = cr; req_wait_rdy = wr; req_bytes = n; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // rd, addr, cread, bytes, wdata, expected read data, expected command byte
  localparam logic [79:0] VEC [8] = '{
    {1'b0, 3'd1, 1'b0, 3'd3, 32'h000A_1B2C, 32'h0000_0000, 8'h08},
    {1'b1, 3'd1, 1'b0, 3'd3, 32'h0000_0000, 32'h000A_1B2C, 8'h48},
    {1'b0, 3'd2, 1'b0, 3'd3, 32'hFFAB_CD12, 32'h0000_0000, 8'h10},
    {1'b1, 3'd2, 1'b0, 3'd3, 32'h0000_0000, 32'h00AB_CD12, 8'h50},
    {1'b0, 3'd5, 1'b0, 3'd1, 32'h0000_773C, 32'h0000_0000, 8'h28},
    {1'b1, 3'd5, 1'b0, 3'd1, 32'h0000_0000, 32'h0000_003C, 8'h68},
    {1'b1, 3'd0, 1'b0, 3'd1, 32'h0000_0000, 32'h0000_0080, 8'h40},
    {1'b1, 3'd6, 1'b0, 3'd3, 32'h0000_0000, 32'h0080_0000, 8'h70}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : main
    int nc0, nd0;
    sregs[0] = 32'h80; sregs[1] = 32'h0; sregs[2] = 32'h0; sregs[3] = 32'h123456;
    sregs[4] = 32'hA5; sregs[5] = 32'h0; sregs[6] = 32'h800000; sregs[7] = 32'h500000;

    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b1 && mosi === 1'b1, "R3 reset link idle", {cs_n, sclk, mosi}, 3'b111);
    chk(done === 1'b0 && busy === 1'b1, "R4 reset done/busy", {done, busy}, 2'b01);
    rst_n = 1'b1;
    wait_idle();
    chk(rst_seen == 1, "R4 48-one interface reset", rst_seen, 1);
    chk(settle_gap >= SETTLE_CYC, "R5 settle gap", settle_gap, SETTLE_CYC);
    chk(last_cmd == 8'h60 && ncmd == 1, "R6 identity read command", {ncmd[23:0], last_cmd}, {24'd1, 8'h60});
    chk(dev_id == 4'h5, "R6 identity nibble", dev_id, 4'h5);

    for (int i = 0; i < 8; i++) begin
      nd0 = ndone;
      issue(VEC[i][79], VEC[i][78:76], VEC[i][75], 1'b0, VEC[i][74:72], VEC[i][71:40]);
      wait_idle();
      chk(last_cmd == VEC[i][7:0], "R1 command byte", last_cmd, VEC[i][7:0]);
      chk(ndone == nd0 + 1, "R9 one done per request", ndone - nd0, 1);
      if (VEC[i][79]) chk(rd_data == VEC[i][39:8], "R2 read payload", rd_data, VEC[i][39:8]);
    end

    // R7: hold link until ready
    drdy_n = 1'b1;
    issue(1'b1, 3'd3, 1'b0, 1'b1, 3'd3, 32'h0);
    repeat (60) @(negedge clk);
    chk(cs_n == 1'b0 && busy == 1'b1 && sclk == 1'b1 && sbit == 0, "R7 bus held without clocking",
        {cs_n, busy, sclk, sbit[7:0]}, {1'b0, 1'b1, 1'b1, 8'd0});
    drdy_n = 1'b0;
    wait_idle();
    chk(last_cmd == 8'h58, "R7 data command after ready", last_cmd, 8'h58);
    chk(rd_data == 32'h0012_3456, "R7 data after ready", rd_data, 32'h0012_3456);

    // R1/R2: continuous-read flag, four-byte data with status appended
    dlen = 4; sregs[3] = 32'h1234_5687;
    issue(1'b1, 3'd3, 1'b1, 1'b1, 3'd4, 32'h0);
    wait_idle();
    chk(last_cmd == 8'h5C, "R1 continuous-read command", last_cmd, 8'h5C);
    chk(rd_data == 32'h1234_5687, "R2 four-byte read", rd_data, 32'h1234_5687);
    // R2: oversized length acts as four bytes
    issue(1'b1, 3'd3, 1'b0, 1'b0, 3'd7, 32'h0);
    wait_idle();
    chk(rd_data == 32'h1234_5687, "R2 length clamp", rd_data, 32'h1234_5687);
    dlen = 3;

    // R8: request during busy is ignored
    nc0 = ncmd; nd0 = ndone;
    issue(1'b0, 3'd6, 1'b0, 1'b0, 3'd3, 32'h0011_1111);
    repeat (20) @(negedge clk);
    issue(1'b0, 3'd7, 1'b0, 1'b0, 3'd3, 32'h0022_2222);
    wait_idle();
    chk(ncmd == nc0 + 1, "R8 one transaction only", ncmd - nc0, 1);
    chk(ndone == nd0 + 1, "R8 one done only", ndone - nd0, 1);
    issue(1'b1, 3'd7, 1'b0, 1'b0, 3'd3, 32'h0);
    wait_idle();
    chk(rd_data == 32'h0050_0000, "R8 ignored write left register", rd_data, 32'h0050_0000);
    issue(1'b1, 3'd6, 1'b0, 1'b0, 3'd3, 32'h0);
    wait_idle();
    chk(rd_data == 32'h0011_1111, "R8 accepted write landed", rd_data, 32'h0011_1111);

    chk(min_gap >= GAP_CYC, "R10 chip-select gap", min_gap, GAP_CYC);
    chk(viol == 0, "R3 clock/data phase", viol, 0);

    // second power-up with a different identity
    @(negedge clk);
    rst_n = 1'b0; rst_seen = 0; sregs[4] = 32'h3B; nc0 = ncmd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_idle();
    chk(rst_seen == 1, "R4 reset sequence repeated", rst_seen, 1);
    chk(settle_gap >= SETTLE_CYC, "R5 settle after re-reset", settle_gap, SETTLE_CYC);
    chk(dev_id == 4'hB, "R6 new identity nibble", dev_id, 4'hB);
    chk(ncmd == nc0 + 1, "R6 single init command", ncmd - nc0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule